// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data addresses for a processor's memory pipeline. It keeps four independent register sets, each made of an index, a signed modify amount, a buffer base and a buffer length. A request names one set and one update operation. The block returns the set's current index as the address and then rewrites that index with its updated value, ready for the next access.

The update can add or subtract the modify value, or step the index by a fixed 2 or 4 in either direction. When the set's length is non-zero, each of these updates stays inside the window that starts at the base and spans the length. An index that steps past the top of the window comes back in at the bottom, and an index that steps below the base comes back in at the top. A separate operation adds the modify value with the carry running from the most significant bit toward the least significant bit. This walks the index through the bit-reversed order needed by radix-2 FFT stages. A hold operation reads the address and leaves the index as it is. The register values are loaded through one write port that selects the set and which of the four registers to load.

Top module: `cbuf_agen`

## Requirements
- R1: Reset (rst_ni low) clears every index, modify, base and length register, clears addr_o to zero and drives addr_vld_o low.
- R2: A request (req_i high at a clock edge) sets addr_o to the selected set's index value as it stood before that edge, with addr_vld_o high in the following cycle. With no request, addr_vld_o is low and addr_o holds its value.
- R3: Operation code 0 adds the modify register (signed) to the index, and code 1 subtracts it. With a length of zero, the result is plain two's-complement arithmetic and no wrap is applied.
- R4: Operation codes 2 and 3 step the index by +2 and −2, and codes 4 and 5 step it by +4 and −4. Both the write-port index and these steps are byte addresses.
- R5: With a non-zero length L and base B, an updated index that moves upward to B+L or beyond has L subtracted from it. Reaching exactly B+L gives B.
- R6: With a non-zero length, an updated index that moves downward below B has L added to it. This applies to a subtract, to a negative step, and to an add of a negative modify value.
- R7: Operation code 6 adds the modify value with the carry running from bit AW−1 down toward bit 0. Any carry out of bit 0 is dropped. No window wrap is applied, whatever the length.
- R8: A request updates only the index of the set it names. The other three sets are unchanged.
- R9: When a write to a set's index register (write kind 0) and a request on that same set happen at the same edge, the returned address is the old index, and the written value is the one that remains.
- R10: Operation code 7 returns the address and leaves the index unchanged.
- R11: The write port selects the register by wr_kind_i: 0 is index, 1 is modify, 2 is base and 3 is length. wr_set_i selects the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register select: 0 index, 1 modify, 2 base, 3 length |
| wr_set_i | input | SW (2) | Set receiving the write |
| wr_data_i | input | AW (32) | Write value |
| req_i | input | 1 | Address request |
| req_set_i | input | SW (2) | Set used by the request |
| req_op_i | input | 3 | Update operation code (0 to 7) |
| addr_o | output | AW (32) | Registered address |
| addr_vld_o | output | 1 | addr_o holds the result of the previous cycle's request |

## Verification
The bench targets the exact window edge. An index that lands on B+L must come back as B. A generator that compared with greater-than instead of greater-or-equal would let the index run one step outside the buffer. Negative steps, subtracts and negative modify values must all wrap back into the top of the window. A design that used the sign of the wrong operand would add L when it should subtract it, or the reverse. The bit-reversed walk is checked across a full 8-point cycle with a length too small to hold that walk. This catches a normal-carry adder and also a wrap applied where none belongs. A simultaneous index write and request on the same set shows whether the write loses to the post-update, and hold requests on the untouched sets catch updates that leak into the wrong set.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC2 = 3'd2,
    OP_DEC2 = 3'd3,
    OP_INC4 = 3'd4,
    OP_DEC4 = 3'd5,
    OP_BREV = 3'd6,
    OP_HOLD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_IDX  = 2'd0,
    K_MOD  = 2'd1,
    K_BASE = 2'd2,
    K_LEN  = 2'd3
  } kind_e;
endpackage

// File: rtl/cbuf_agen_brev.sv
module cbuf_agen_brev #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] a_r, b_r, s_r;

  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign a_r[g]          = a_i[AW-1-g];
    assign b_r[g]          = b_i[AW-1-g];
    assign sum_o[AW-1-g]   = s_r[g];
  end

  // normal add in reversed domain = carry toward LSB in natural domain
  assign s_r = a_r + b_r;
endmodule

// File: rtl/cbuf_agen_step.sv
module cbuf_agen_step
  import cbuf_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  op_e           op_i,
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] nxt_o
);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] FOUR = AW'(4);

  logic [AW-1:0] delta, raw, off, brev_sum;
  logic          wrap_hit;

  cbuf_agen_brev #(.AW(AW)) u_brev (
    .a_i  (idx_i),
    .b_i  (mod_i),
    .sum_o(brev_sum)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD:  delta = mod_i;
      OP_SUB:  delta = -mod_i;
      OP_INC2: delta = TWO;
      OP_DEC2: delta = -TWO;
      OP_INC4: delta = FOUR;
      OP_DEC4: delta = -FOUR;
      default: delta = '0;
    endcase
  end

  assign raw      = idx_i + delta;
  assign off      = raw - base_i;
  // below base wraps modulo 2^AW, so one unsigned compare covers both sides
  assign wrap_hit = (len_i != '0) && (off >= len_i);

  always_comb begin
    if (op_i == OP_HOLD)      nxt_o = idx_i;
    else if (op_i == OP_BREV) nxt_o = brev_sum;
    else if (!wrap_hit)       nxt_o = raw;
    else if (delta[AW-1])     nxt_o = raw + len_i;
    else                      nxt_o = raw - len_i;
  end
endmodule

// File: rtl/cbuf_agen_regs.sv
module cbuf_agen_regs
  import cbuf_agen_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int AW       = 32,
  parameter int SW       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [SW-1:0] wr_set_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [SW-1:0] upd_set_i,
  input  logic [AW-1:0] upd_val_i,
  input  logic [SW-1:0] rd_set_i,
  output logic [AW-1:0] rd_idx_o,
  output logic [AW-1:0] rd_mod_o,
  output logic [AW-1:0] rd_base_o,
  output logic [AW-1:0] rd_len_o
);
  logic [AW-1:0] idx_q  [NUM_SETS];
  logic [AW-1:0] mod_q  [NUM_SETS];
  logic [AW-1:0] base_q [NUM_SETS];
  logic [AW-1:0] len_q  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_set_i == SW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q[s]  <= '0;
        mod_q[s]  <= '0;
        base_q[s] <= '0;
        len_q[s]  <= '0;
      end else begin
        // explicit index write beats the post-update
        if (wr_hit && wr_kind_i == K_IDX)       idx_q[s] <= wr_data_i;
        else if (upd_en_i && upd_set_i == SW'(s)) idx_q[s] <= upd_val_i;
        if (wr_hit && wr_kind_i == K_MOD)  mod_q[s]  <= wr_data_i;
        if (wr_hit && wr_kind_i == K_BASE) base_q[s] <= wr_data_i;
        if (wr_hit && wr_kind_i == K_LEN)  len_q[s]  <= wr_data_i;
      end
    end
  end

  assign rd_idx_o  = idx_q[rd_set_i];
  assign rd_mod_o  = mod_q[rd_set_i];
  assign rd_base_o = base_q[rd_set_i];
  assign rd_len_o  = len_q[rd_set_i];
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
  import cbuf_agen_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int AW       = 32,
  localparam int SW      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [SW-1:0] wr_set_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          req_i,
  input  logic [SW-1:0] req_set_i,
  input  logic [2:0]    req_op_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o
);
  logic [AW-1:0] sel_idx, sel_mod, sel_base, sel_len, idx_nxt;

  cbuf_agen_regs #(.NUM_SETS(NUM_SETS), .AW(AW), .SW(SW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_kind_i(wr_kind_i),
    .wr_set_i (wr_set_i),
    .wr_data_i(wr_data_i),
    .upd_en_i (req_i),
    .upd_set_i(req_set_i),
    .upd_val_i(idx_nxt),
    .rd_set_i (req_set_i),
    .rd_idx_o (sel_idx),
    .rd_mod_o (sel_mod),
    .rd_base_o(sel_base),
    .rd_len_o (sel_len)
  );

  cbuf_agen_step #(.AW(AW)) u_step (
    .op_i  (op_e'(req_op_i)),
    .idx_i (sel_idx),
    .mod_i (sel_mod),
    .base_i(sel_base),
    .len_i (sel_len),
    .nxt_o (idx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
    end else begin
      addr_vld_o <= req_i;
      if (req_i) addr_o <= sel_idx;
    end
  end
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [2:0]    req_op_i,
  input logic [AW-1:0] addr_o,
  input logic          addr_vld_o,
  input logic [AW-1:0] cur_idx,
  input logic [AW-1:0] cur_mod,
  input logic [AW-1:0] cur_base,
  input logic [AW-1:0] cur_len,
  input logic [AW-1:0] nxt_idx
);
  logic wrap_op;
  assign wrap_op = (req_op_i != 3'd6) && (req_op_i != 3'd7);

  p_vld_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> addr_vld_o);

  p_vld_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !addr_vld_o);

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(addr_o));

  p_addr_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> addr_o == $past(cur_idx));

  // covers both wrap directions (R5, R6)
  p_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wrap_op && cur_len != '0 && (cur_idx - cur_base) < cur_len)
      |-> (nxt_idx - cur_base) < cur_len);

  p_linear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_op_i == 3'd0 && cur_len == '0) |-> nxt_idx == cur_idx + cur_mod);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_op_i == 3'd7) |-> nxt_idx == cur_idx);
endmodule

bind cbuf_agen cbuf_agen_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .req_op_i  (req_op_i),
  .addr_o    (addr_o),
  .addr_vld_o(addr_vld_o),
  .cur_idx   (sel_idx),
  .cur_mod   (sel_mod),
  .cur_base  (sel_base),
  .cur_len   (sel_len),
  .nxt_idx   (idx_nxt)
);

// File: tb/cbuf_agen_tb.sv
module cbuf_agen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 2;

  typedef struct packed {
    logic        wr;
    logic [1:0]  kind;
    logic [1:0]  set;
    logic [2:0]  op;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t wv(input logic [1:0] k, input logic [1:0] s, input logic [31:0] d);
    return '{1'b1, k, s, 3'd0, d, 32'h0, 4'd11};
  endfunction

  function automatic vec_t rv(input logic [1:0] s, input logic [2:0] o, input logic [31:0] e,
                              input logic [3:0] r);
    return '{1'b0, 2'd0, s, o, 32'h0, e, r};
  endfunction

  // ops: 0 add, 1 sub, 2 +2, 3 -2, 4 +4, 5 -4, 6 brev, 7 hold; kinds: 0 I, 1 M, 2 B, 3 L
  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    wv(0,0,32'h100), wv(1,0,32'h8),                     // R11 set0 linear
    rv(0,0,32'h100,3), rv(0,0,32'h108,3),               // R3
    rv(0,2,32'h110,4), rv(0,5,32'h112,4),               // R4
    rv(0,4,32'h10E,4), rv(0,3,32'h112,4),               // R4
    rv(0,1,32'h110,3), rv(0,7,32'h108,10), rv(0,7,32'h108,10), // R3 R10
    wv(2,1,32'h200), wv(3,1,32'h10), wv(0,1,32'h208), wv(1,1,32'h6),
    rv(1,0,32'h208,3), rv(1,0,32'h20E,5), rv(1,0,32'h204,5), // R5 wrap up
    rv(1,1,32'h20A,6), rv(1,1,32'h204,6), rv(1,4,32'h20E,5), // R6 wrap down
    rv(1,5,32'h202,6), rv(1,7,32'h20E,6),
    wv(0,1,32'h20A), rv(1,0,32'h20A,5), rv(1,7,32'h200,5), // R5 exact B+L
    wv(1,1,32'hFFFF_FFFA), rv(1,0,32'h200,6), rv(1,7,32'h20A,6), // R6 negative modify
    wv(0,2,32'h1000), wv(2,2,32'h1000), wv(3,2,32'h3), wv(1,2,32'h4),
    rv(2,6,32'h1000,7), rv(2,6,32'h1004,7), rv(2,6,32'h1002,7), rv(2,6,32'h1006,7), // R7
    rv(2,6,32'h1001,7), rv(2,6,32'h1005,7), rv(2,6,32'h1003,7), rv(2,6,32'h1007,7),
    rv(2,7,32'h1000,7),
    rv(0,7,32'h108,8), rv(1,7,32'h20A,8)                // R8
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_kind_i = '0;
  logic [SW-1:0] wr_set_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic          req_i = 1'b0;
  logic [SW-1:0] req_set_i = '0;
  logic [2:0]    req_op_i = '0;
  logic [AW-1:0] addr_o;
  logic          addr_vld_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cbuf_agen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_set_i(wr_set_i), .wr_data_i(wr_data_i),
    .req_i(req_i), .req_set_i(req_set_i), .req_op_i(req_op_i),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] k, input logic [1:0] s, input logic [31:0] d);
    wr_en_i = 1'b1; wr_kind_i = k; wr_set_i = s; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] s, input logic [2:0] o, input logic [31:0] e,
                        input logic [3:0] r);
    req_i = 1'b1; req_set_i = s; req_op_i = o;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 1'b0;
    check($sformatf("R%0d addr", r), addr_o, e);
    check("R2 vld", {31'b0, addr_vld_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset addr", addr_o, 32'h0);
    check("R1 reset vld", {31'b0, addr_vld_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_write(VEC[i].kind, VEC[i].set, VEC[i].data);
      else           do_req(VEC[i].set, VEC[i].op, VEC[i].exp, VEC[i].rq);
    end

    // R2: idle cycle drops valid and holds address
    @(negedge clk_i);
    check("R2 idle vld", {31'b0, addr_vld_o}, 32'd0);
    check("R2 idle addr", addr_o, 32'h20A);

    // R9: same-edge index write and request on set 3
    do_write(2'd1, 2'd3, 32'h10);
    wr_en_i = 1'b1; wr_kind_i = 2'd0; wr_set_i = 2'd3; wr_data_i = 32'h400;
    req_i = 1'b1; req_set_i = 2'd3; req_op_i = 3'd0;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0; req_i = 1'b0;
    check("R9 old addr", addr_o, 32'h0);
    do_req(2'd3, 3'd7, 32'h400, 4'd9);

    // R1: reset mid-run clears every set, including modify
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid addr", addr_o, 32'h0);
    check("R1 mid vld", {31'b0, addr_vld_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_req(2'd1, 3'd7, 32'h0, 4'd1);
    do_req(2'd0, 3'd0, 32'h0, 4'd1);
    do_req(2'd0, 3'd7, 32'h0, 4'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule